// File: doc/BRIEF.md
# CEC Receive Frame Queue

This block buffers whole received frames for a consumer-electronics-control controller. A bit-level receive engine hands over one byte at a time on a valid/ready stream. The first byte of a frame is the header, whose low nibble names the destination; the second byte is the opcode, and every later byte is an operand. The engine marks the final byte of a frame with `rx_last` and flags any damaged byte with `rx_err`. The block keeps only frames whose destination is enabled in a 16-bit logical-address mask, or whose destination is the broadcast address 15. An accepted frame occupies one of `DEPTH` slots (default 4) once its last byte is in. A frame that arrives while every slot is taken is dropped.

A host sees the oldest frame through a small register file. Every register is 8 bits wide and sits on a word-spaced byte address. The host reads one packed status byte, then the header, the opcode and the operands. It then retires the frame with a self-clearing discard bit, or empties the whole queue with a self-clearing flush command. An interrupt status register, cleared by writing 1 to a bit, records new frames and overflows. An enable register gates these bits onto `irq`.

Stream rules: a byte transfers on a rising edge where `rx_valid` and `rx_ready` are both high. `rx_ready` drops only in the single cycle in which a flush executes. The engine must hold the byte and its flags stable until the transfer happens. The block never stalls for lack of space, because a full queue drops the frame instead.

Top module: `cec_rx_frame_fifo`

## Requirements
- R1: The status byte at address 0x00 holds the number of queued frames in bits 6:4, the oldest frame's error flag in bit 7 and its operand count in bits 3:0. It reads 0 after reset and whenever the queue is empty.
- R2: The oldest frame's header reads at 0x04 and its opcode at 0x08. Operand i (i = 0..13) reads at 0x20 + 4*i.
- R3: Writing a value with bit 0 set and bit 1 clear to the control register at 0x0C discards the oldest frame. The control register reads 0x01 in the cycle after the write and 0x00 once the discard has taken effect one cycle later.
- R4: Writing 0x3 to the control register empties the queue. The register reads 0x03 in the cycle after the write and 0x00, with a frame count of 0, one cycle later.
- R5: Interrupt status at 0x10 sets bit 1 when a frame is queued and bit 3 when a frame is dropped for lack of space. Writing 1 to a bit clears it. Enable bits at 0x14 in the same positions gate the status bits onto `irq` (logical OR).
- R6: The acceptance mask is written at 0x18 (addresses 0–7, bit n for address n) and at 0x1C (addresses 8–15, bit n for address n+8). A frame whose header bits 3:0 select a clear mask bit is not queued.
- R7: A frame addressed to 15 is queued whatever the mask holds, including an all-zero mask.
- R8: If `rx_err` is high on any byte of a frame, the frame is still queued with its error flag set. It is retired by the same discard as a good frame.
- R9: The operand count is the frame's byte count minus 2, floored at 0 and capped at 14. Bytes beyond the 16th are not stored.
- R10: The queue holds `DEPTH` frames. An accepted frame whose header arrives while the queue is full is dropped, and interrupt status bit 3 is set.
- R11: `rx_ready` is high except in the one cycle in which a flush executes.
- R12: Frames are presented to the host in the order in which they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Block takes the byte on this edge |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Byte ends the frame |
| rx_err | input | 1 | Byte was received with an error |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Enabled interrupt status present |

## Verification
The address filter is swept exhaustively. For each single-bit mask and for an empty mask, a frame is sent to all sixteen destinations, which separates a mask-bit match from the broadcast override and exposes an off-by-one in the mask byte split. Frame lengths from 1 to 18 bytes check the operand count floor, its cap and the stored byte positions. A five-frame burst shows arrival order and the overflow drop. Frames with a damaged middle byte, a flush with frames waiting, and interrupt clearing then check the error flag, the flush command and the interrupt bits.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int FRAME_BYTES = 16;
  localparam int MAX_OPS     = FRAME_BYTES - 2;

  localparam logic [7:0] A_STATUS  = 8'h00;
  localparam logic [7:0] A_HEADER  = 8'h04;
  localparam logic [7:0] A_OPCODE  = 8'h08;
  localparam logic [7:0] A_CTRL    = 8'h0C;
  localparam logic [7:0] A_IST     = 8'h10;
  localparam logic [7:0] A_IEN     = 8'h14;
  localparam logic [7:0] A_MASK_LO = 8'h18;
  localparam logic [7:0] A_MASK_HI = 8'h1C;
  localparam logic [7:0] A_OPD     = 8'h20;

  localparam int IST_RXNE = 1;
  localparam int IST_OVF  = 3;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'b00,
    CT_POP   = 2'b01,
    CT_FLUSH = 2'b11
  } ctrl_e;
endpackage

// File: rtl/cec_rx_assembler.sv
module cec_rx_assembler
  import cec_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_byte,
  input  logic        rx_last,
  input  logic        rx_err,
  input  logic [15:0] mask,
  input  logic        full,
  input  logic        flush,
  output logic        byte_we,
  output logic [3:0]  byte_idx,
  output logic [7:0]  byte_data,
  output logic        commit,
  output logic [3:0]  commit_cnt,
  output logic        commit_err,
  output logic        overflow
);
  localparam logic [4:0] IDX_SAT = 5'(FRAME_BYTES);

  logic       in_frame, keep_q, err_q;
  logic [4:0] idx_q, cur_idx, nbytes;
  logic       hs, hdr_ok, keep_now, err_acc;

  assign rx_ready  = !flush;
  assign hs        = rx_valid && rx_ready;
  assign hdr_ok    = mask[rx_byte[3:0]] || (rx_byte[3:0] == 4'hF);
  assign keep_now  = in_frame ? keep_q : (hdr_ok && !full);
  assign cur_idx   = in_frame ? idx_q : 5'd0;
  assign nbytes    = cur_idx + 5'd1;
  assign err_acc   = in_frame && err_q;

  assign byte_we    = hs && keep_now && (cur_idx < IDX_SAT);
  assign byte_idx   = cur_idx[3:0];
  assign byte_data  = rx_byte;
  assign commit     = hs && rx_last && keep_now;
  assign commit_err = err_acc || rx_err;
  assign overflow   = hs && !in_frame && hdr_ok && full;

  always_comb begin
    if (nbytes <= 5'd2)            commit_cnt = 4'd0;
    else if (nbytes >= IDX_SAT)    commit_cnt = 4'(MAX_OPS);
    else                           commit_cnt = 4'(nbytes - 5'd2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      keep_q   <= 1'b0;
      err_q    <= 1'b0;
      idx_q    <= '0;
    end else if (flush) begin
      keep_q <= 1'b0;
    end else if (hs) begin
      in_frame <= !rx_last;
      keep_q   <= keep_now;
      err_q    <= err_acc || rx_err;
      idx_q    <= (cur_idx == IDX_SAT) ? IDX_SAT : nbytes;
    end
  end

  AST_OPCNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_cnt <= 4'(MAX_OPS))); // R9
endmodule

// File: rtl/cec_rx_store.sv
module cec_rx_store
  import cec_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              byte_we,
  input  logic [3:0]                        byte_idx,
  input  logic [7:0]                        byte_data,
  input  logic                              commit,
  input  logic [3:0]                        commit_cnt,
  input  logic                              commit_err,
  input  logic                              pop,
  input  logic                              flush,
  input  logic [3:0]                        op_sel,
  output logic [$clog2(DEPTH+1)-1:0]        count,
  output logic                              full,
  output logic [7:0]                        head_hdr,
  output logic [7:0]                        head_opc,
  output logic [3:0]                        head_cnt,
  output logic                              head_err,
  output logic [7:0]                        head_opd
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH-1);

  logic [7:0]       mem [DEPTH][FRAME_BYTES];
  logic [3:0]       cnt_q [DEPTH];
  logic [DEPTH-1:0] err_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop_eff;

  assign full     = (count == CNT_W'(DEPTH));
  assign pop_eff  = pop && (count != '0);
  assign head_hdr = mem[rd_ptr][0];
  assign head_opc = mem[rd_ptr][1];
  assign head_opd = mem[rd_ptr][4'(op_sel + 4'd2)];
  assign head_cnt = cnt_q[rd_ptr];
  assign head_err = err_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (byte_we) mem[wr_ptr][byte_idx] <= byte_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      err_q  <= '0;
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (commit) begin
        cnt_q[wr_ptr] <= commit_cnt;
        err_q[wr_ptr] <= commit_err;
        wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      end
      if (pop_eff) rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(commit) - CNT_W'(pop_eff);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R10
  AST_NO_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !full); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R4
endmodule

// File: rtl/cec_rx_regs.sv
module cec_rx_regs
  import cec_rx_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  input  logic [CNT_W-1:0] count,
  input  logic [7:0]       head_hdr,
  input  logic [7:0]       head_opc,
  input  logic [3:0]       head_cnt,
  input  logic             head_err,
  input  logic [7:0]       head_opd,
  input  logic             commit,
  input  logic             overflow,
  output logic             pop,
  output logic             flush,
  output logic [15:0]      mask,
  output logic [3:0]       op_sel
);
  ctrl_e      ctrl_q;
  logic [7:0] ist_q, ien_q, off;
  logic [7:0] ist_set, ist_clr;
  logic       empty, in_opd;

  assign pop    = (ctrl_q == CT_POP);
  assign flush  = (ctrl_q == CT_FLUSH);
  assign irq    = |(ist_q & ien_q);
  assign empty  = (count == '0);
  assign off    = reg_addr - A_OPD;
  assign op_sel = off[5:2];
  assign in_opd = (reg_addr >= A_OPD) && (off < 8'(4*MAX_OPS)) && (off[1:0] == 2'b00);

  always_comb begin
    ist_set = '0;
    ist_set[IST_RXNE] = commit;
    ist_set[IST_OVF]  = overflow;
    ist_clr = (reg_we && reg_addr == A_IST) ? reg_wdata : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CT_IDLE;
      ist_q  <= '0;
      ien_q  <= '0;
      mask   <= '0;
    end else begin
      if (ctrl_q != CT_IDLE)
        ctrl_q <= CT_IDLE;
      else if (reg_we && reg_addr == A_CTRL)
        ctrl_q <= (reg_wdata[1:0] == 2'b11) ? CT_FLUSH :
                  (reg_wdata[1:0] == 2'b01) ? CT_POP : CT_IDLE;
      ist_q <= (ist_q & ~ist_clr) | ist_set;
      if (reg_we && reg_addr == A_IEN)     ien_q      <= reg_wdata;
      if (reg_we && reg_addr == A_MASK_LO) mask[7:0]  <= reg_wdata;
      if (reg_we && reg_addr == A_MASK_HI) mask[15:8] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_opd) reg_rdata = head_opd;
    else case (reg_addr)
      A_STATUS:  reg_rdata = empty ? 8'h00 : {head_err, 3'(count), head_cnt};
      A_HEADER:  reg_rdata = head_hdr;
      A_OPCODE:  reg_rdata = head_opc;
      A_CTRL:    reg_rdata = {6'd0, ctrl_q};
      A_IST:     reg_rdata = ist_q;
      A_IEN:     reg_rdata = ien_q;
      A_MASK_LO: reg_rdata = mask[7:0];
      A_MASK_HI: reg_rdata = mask[15:8];
      default:   reg_rdata = 8'h00;
    endcase
  end

  AST_CTRL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != CT_IDLE) |=> (ctrl_q == CT_IDLE)); // R3
  AST_RXNE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ist_q[IST_RXNE]); // R5
  AST_OVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> ist_q[IST_OVF]); // R10
endmodule

// File: rtl/cec_rx_frame_fifo.sv
module cec_rx_frame_fifo
  import cec_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_byte,
  input  logic       rx_last,
  input  logic       rx_err,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic             byte_we, commit, commit_err, overflow, full, pop, flush;
  logic [3:0]       byte_idx, commit_cnt, head_cnt, op_sel;
  logic [7:0]       byte_data, head_hdr, head_opc, head_opd;
  logic             head_err;
  logic [15:0]      mask;
  logic [CNT_W-1:0] count;

  cec_rx_assembler u_asm (
    .clk, .rst_n, .rx_valid, .rx_ready, .rx_byte, .rx_last, .rx_err,
    .mask, .full, .flush, .byte_we, .byte_idx, .byte_data,
    .commit, .commit_cnt, .commit_err, .overflow
  );

  cec_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .byte_we, .byte_idx, .byte_data, .commit, .commit_cnt,
    .commit_err, .pop, .flush, .op_sel, .count, .full,
    .head_hdr, .head_opc, .head_cnt, .head_err, .head_opd
  );

  cec_rx_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .count, .head_hdr, .head_opc, .head_cnt, .head_err, .head_opd,
    .commit, .overflow, .pop, .flush, .mask, .op_sel
  );
endmodule

// File: tb/cec_rx_frame_fifo_tb.sv
module cec_rx_frame_fifo_tb;
  import cec_rx_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0, reg_we = 1'b0;
  logic [7:0] rx_byte = '0, reg_addr = '0, reg_wdata = '0;
  logic       rx_ready, irq;
  logic [7:0] reg_rdata;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cec_rx_frame_fifo u_dut (
    .clk, .rst_n, .rx_valid, .rx_ready, .rx_byte, .rx_last, .rx_err,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a;
    #0.5;
    v = int'(reg_rdata);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 37) & 8'hFF);
  endfunction

  task automatic send(input int len, input logic [7:0] hdr, input int seed, input int errpos);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = (i == 0) ? hdr : pat(seed, i);
      rx_last  = (i == len - 1);
      rx_err   = (i == errpos);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic pop_frame(input string req);
    int v;
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, v); check({req, " R3 ctrl busy"}, v, 1);
    @(negedge clk);
    rd(A_CTRL, v); check({req, " R3 ctrl cleared"}, v, 0);
  endtask

  task automatic flush_all();
    int v;
    wr(A_CTRL, 8'h03);
    rd(A_CTRL, v); check("R4 ctrl busy", v, 3);
    check("R11 ready low in flush", int'(rx_ready), 0);
    @(negedge clk);
    rd(A_CTRL, v); check("R4 ctrl cleared", v, 0);
    rd(A_STATUS, v); check("R4 empty after flush", v, 0);
    check("R11 ready back", int'(rx_ready), 1);
  endtask

  initial begin
    int v, exp_cnt, ops;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_STATUS, v); check("R1 reset status", v, 0);
    rd(A_IST, v);    check("R5 reset ist", v, 0);
    check("R5 reset irq", int'(irq), 0);
    check("R11 reset ready", int'(rx_ready), 1);

    // R6 R7: single-bit masks (a=0..15) and empty mask (a=16), all destinations
    for (int a = 0; a <= 16; a++) begin
      wr(A_MASK_LO, (a < 8)  ? 8'(1 << a) : 8'h00);
      wr(A_MASK_HI, (a >= 8 && a < 16) ? 8'(1 << (a - 8)) : 8'h00);
      exp_cnt = 0;
      for (int d = 0; d < 16; d++) begin
        send(3, {4'h4, 4'(d)}, d, -1);
        if (d == a || d == 15) exp_cnt++;
        rd(A_STATUS, v);
        check((d == 15) ? "R7 broadcast accept" : "R6 mask filter", (v >> 4) & 7, exp_cnt);
      end
      flush_all();
    end

    // R9 R2 R3 R1: length sweep with all addresses enabled
    wr(A_MASK_LO, 8'hFF);
    wr(A_MASK_HI, 8'hFF);
    for (int len = 1; len <= 18; len++) begin
      ops = (len <= 2) ? 0 : ((len - 2 > 14) ? 14 : len - 2);
      send(len, {4'(len), 4'h3}, len * 5, -1);
      rd(A_STATUS, v); check("R9 R1 status opcount", v, 8'h10 | ops);
      rd(A_HEADER, v); check("R2 header", v, int'({4'(len), 4'h3}));
      if (len >= 2) begin
        rd(A_OPCODE, v); check("R2 opcode", v, int'(pat(len * 5, 1)));
      end
      for (int i = 0; i < ops; i++) begin
        rd(8'(A_OPD + 4 * i), v); check("R2 operand", v, int'(pat(len * 5, i + 2)));
      end
      pop_frame("len");
      rd(A_STATUS, v); check("R1 empty after pop", v, 0);
    end

    // R10 R12 R5: burst of five frames
    wr(A_IST, 8'hFF);
    wr(A_IEN, 8'h0A);
    for (int k = 0; k < 5; k++) begin
      send(2, {4'(k), 4'h1}, k, -1);
      rd(A_IST, v);
      check("R10 overflow bit", (v >> 3) & 1, (k == 4) ? 1 : 0);
      check("R5 rxne bit", (v >> 1) & 1, 1);
    end
    rd(A_STATUS, v); check("R10 full count", (v >> 4) & 7, 4);
    check("R5 irq", int'(irq), 1);
    wr(A_IST, 8'h08);
    rd(A_IST, v); check("R5 w1c overflow only", v, 8'h02);
    wr(A_IST, 8'h02);
    rd(A_IST, v); check("R5 w1c rxne", v, 0);
    check("R5 irq cleared", int'(irq), 0);
    for (int k = 0; k < 4; k++) begin
      rd(A_HEADER, v); check("R12 arrival order", v, int'({4'(k), 4'h1}));
      pop_frame("order");
    end
    rd(A_STATUS, v); check("R10 dropped frame absent", v, 0);
    wr(A_IEN, 8'h02);
    send(1, 8'h21, 0, -1);
    check("R5 irq on new frame", int'(irq), 1);
    wr(A_IEN, 8'h00);
    check("R5 irq gated by enable", int'(irq), 0);
    pop_frame("irq");

    // R8: error on a middle byte, then a clean frame
    send(4, 8'h52, 9, 2);
    send(3, 8'h62, 9, -1);
    rd(A_STATUS, v); check("R8 error head", v, 8'hA2);
    pop_frame("err");
    rd(A_STATUS, v); check("R8 clean next", v, 8'h11);
    rd(A_HEADER, v); check("R8 next header", v, 8'h62);
    pop_frame("err2");

    // R4: flush with frames waiting, then resume
    send(3, 8'h11, 1, -1);
    send(3, 8'h12, 2, -1);
    flush_all();
    send(3, 8'h77, 3, -1);
    rd(A_HEADER, v); check("R4 resume after flush", v, 8'h77);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule